// File: doc/BRIEF.md
# DMA Element/Frame Address Generator

This block produces the read-side and write-side byte addresses for one DMA channel that moves a block. A block is a number of frames, and each frame is a number of elements. A load strobe captures the two start addresses and a 32-bit transfer-count word. Each element-done strobe then moves both addresses forward according to the mode chosen for that side. The generator counts down the remaining elements and frames, and it raises a frame-end flag and a block-end flag on the strobe that completes each one.

Each side has its own element size and addressing mode. In indexed mode, each side has a signed element offset and a signed frame offset. These offsets are raw byte distances. They are never scaled by the element size, so a step that is not a whole element is allowed. Such a step is reported through a misalignment flag for that side. The bus protocol, the data path and arbitration are handled by other logic. Mode, size and offset inputs are used live and must stay steady while a block is running.

Top module: `dma_agen`

## Requirements
- R1: A cycle with `load` high captures `src_start`, `dst_start`, the element count from `xfer_count[15:0]` and the frame count from `xfer_count[31:16]`. A count of zero is taken as one. When `load` and `elem_done` are high in the same cycle, `load` wins.
- R2: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. `rd_size` applies to the source side and `wr_size` to the destination side, each on its own.
- R3: Mode codes are 0 = constant, 1 = post-increment, 2 = indexed and 3 = constant. A side in constant mode keeps its address unchanged for the whole block.
- R4: In post-increment mode, the address grows by the side's element size on every element, including across frame boundaries. The index offsets have no effect in this mode.
- R5: In indexed mode, the element index is added after every element except the last one of a frame. After the last element of a frame, the frame index is added instead.
- R6: Index offsets are byte counts used as given. An element index of 2 with 8-byte elements moves the address by 2.
- R7: An indexed side whose element index and frame index are both zero keeps its address fixed.
- R8: `src_misalign` (or `dst_misalign`) is high exactly when that side's current address is not a multiple of that side's element size.
- R9: `frame_end` is high during a cycle with an accepted `elem_done` while `elem_left` is 1. Otherwise an accepted strobe lowers `elem_left` by one. At a frame end, `elem_left` reloads and `frame_left` drops by one.
- R10: `block_end` is high when `frame_end` is high and `frame_left` is 1. On that edge, both counts and both addresses return to their loaded values.
- R11: Index offsets are 13-bit two's-complement values, sign-extended before they are added, so negative offsets move the address down.
- R12: After reset, all outputs are zero. An `elem_done` strobe while `elem_left` is zero has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture start addresses and counts |
| src_start | input | 32 | Source start byte address |
| dst_start | input | 32 | Destination start byte address |
| xfer_count | input | 32 | Frame count [31:16], element count [15:0] |
| rd_size | input | 2 | Source element size code |
| wr_size | input | 2 | Destination element size code |
| src_mode | input | 2 | Source addressing mode code |
| dst_mode | input | 2 | Destination addressing mode code |
| src_eidx | input | 13 | Source signed element index (bytes) |
| src_fidx | input | 13 | Source signed frame index (bytes) |
| dst_eidx | input | 13 | Destination signed element index (bytes) |
| dst_fidx | input | 13 | Destination signed frame index (bytes) |
| elem_done | input | 1 | One element has been moved |
| src_addr | output | 32 | Current source byte address |
| dst_addr | output | 32 | Current destination byte address |
| elem_left | output | 16 | Elements left in the current frame |
| frame_left | output | 16 | Frames left in the block |
| frame_end | output | 1 | This strobe completes a frame |
| block_end | output | 1 | This strobe completes the block |
| src_misalign | output | 1 | Source address not size-aligned |
| dst_misalign | output | 1 | Destination address not size-aligned |

## Verification
The main sweep pairs the two sides under different settings.

- Post-increment is run with nonzero offsets present, which exposes any leak of the index into that mode.
- Indexed mode is run with a positive element index and a negative frame index that rewinds each frame. This separates the frame-boundary substitution from a plain sum of both offsets.
- A 2-byte index on 8-byte elements separates raw byte offsets from scaled ones and also exercises the misalignment flag.
- Zero indices and both constant codes show the held-address cases.
- Single-element frames make every strobe a frame end.

Directed cases then cover the idle strobe, a zero count word, and a load issued together with a strobe.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;

  typedef enum logic [1:0] {
    AM_CONST   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_INDEXED = 2'd2,
    AM_CONST2  = 2'd3
  } amode_e;

  // Byte count of one element for a size code (1, 2, 4, 8)
  function automatic logic [3:0] elem_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/dma_agen_count.sv
module dma_agen_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] elem_init,
  input  logic [CNT_W-1:0] frame_init,
  input  logic             elem_done,
  output logic [CNT_W-1:0] elem_left,
  output logic [CNT_W-1:0] frame_left,
  output logic             adv,
  output logic             frm_last,
  output logic             blk_last
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] elem_rld, frame_rld;
  logic [CNT_W-1:0] elem_norm, frame_norm;

  // A count of zero behaves as one
  function automatic logic [CNT_W-1:0] norm_cnt(input logic [CNT_W-1:0] c);
    return (c == '0) ? ONE : c;
  endfunction

  assign elem_norm  = norm_cnt(elem_init);
  assign frame_norm = norm_cnt(frame_init);

  assign adv      = elem_done && !load && (elem_left != '0);
  assign frm_last = (elem_left == ONE);
  assign blk_last = frm_last && (frame_left == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_left  <= '0;
      frame_left <= '0;
      elem_rld   <= '0;
      frame_rld  <= '0;
    end else if (load) begin
      elem_left  <= elem_norm;
      frame_left <= frame_norm;
      elem_rld   <= elem_norm;
      frame_rld  <= frame_norm;
    end else if (adv) begin
      if (blk_last) begin
        elem_left  <= elem_rld;
        frame_left <= frame_rld;
      end else if (frm_last) begin
        elem_left  <= elem_rld;
        frame_left <= frame_left - ONE;
      end else begin
        elem_left  <= elem_left - ONE;
      end
    end
  end

endmodule

// File: rtl/dma_agen_side.sv
module dma_agen_side
  import dma_agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  input  logic [IDX_W-1:0]  eidx,
  input  logic [IDX_W-1:0]  fidx,
  input  logic              adv,
  input  logic              frm_last,
  input  logic              blk_last,
  output logic [ADDR_W-1:0] addr,
  output logic              misalign
);

  localparam int EXT_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] size_mask;

  function automatic logic [ADDR_W-1:0] sext(input logic [IDX_W-1:0] v);
    return {{EXT_W{v[IDX_W-1]}}, v};
  endfunction

  // Byte step taken after the current element
  function automatic logic [ADDR_W-1:0] step_of(
    input amode_e           m,
    input logic [1:0]       sz,
    input logic [IDX_W-1:0] ei,
    input logic [IDX_W-1:0] fi,
    input logic             last
  );
    case (m)
      AM_POSTINC: return ADDR_W'(elem_bytes(sz));
      AM_INDEXED: return last ? sext(fi) : sext(ei);
      default:    return '0;
    endcase
  endfunction

  assign inc       = step_of(amode_e'(mode), size, eidx, fidx, frm_last);
  assign size_mask = ADDR_W'(elem_bytes(size)) - ADDR_W'(1);
  assign misalign  = (addr & size_mask) != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      start_q <= '0;
    end else if (load) begin
      addr    <= start;
      start_q <= start;
    end else if (adv) begin
      addr <= blk_last ? start_q : (addr + inc);
    end
  end

endmodule

// File: rtl/dma_agen.sv
module dma_agen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] src_start,
  input  logic [ADDR_W-1:0] dst_start,
  input  logic [2*CNT_W-1:0] xfer_count,
  input  logic [1:0]        rd_size,
  input  logic [1:0]        wr_size,
  input  logic [1:0]        src_mode,
  input  logic [1:0]        dst_mode,
  input  logic [IDX_W-1:0]  src_eidx,
  input  logic [IDX_W-1:0]  src_fidx,
  input  logic [IDX_W-1:0]  dst_eidx,
  input  logic [IDX_W-1:0]  dst_fidx,
  input  logic              elem_done,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [CNT_W-1:0]  elem_left,
  output logic [CNT_W-1:0]  frame_left,
  output logic              frame_end,
  output logic              block_end,
  output logic              src_misalign,
  output logic              dst_misalign
);

  localparam int NSIDE = 2;

  // Internal events, named for the checker
  logic adv, frm_last, blk_last;

  logic [NSIDE-1:0][ADDR_W-1:0] s_start, s_addr;
  logic [NSIDE-1:0][1:0]        s_mode, s_size;
  logic [NSIDE-1:0][IDX_W-1:0]  s_eidx, s_fidx;
  logic [NSIDE-1:0]             s_mis;

  dma_agen_count #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .elem_init  (xfer_count[CNT_W-1:0]),
    .frame_init (xfer_count[2*CNT_W-1:CNT_W]),
    .elem_done  (elem_done),
    .elem_left  (elem_left),
    .frame_left (frame_left),
    .adv        (adv),
    .frm_last   (frm_last),
    .blk_last   (blk_last)
  );

  assign s_start = {dst_start, src_start};
  assign s_mode  = {dst_mode, src_mode};
  assign s_size  = {wr_size, rd_size};
  assign s_eidx  = {dst_eidx, src_eidx};
  assign s_fidx  = {dst_fidx, src_fidx};

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_agen_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .start    (s_start[g]),
      .mode     (s_mode[g]),
      .size     (s_size[g]),
      .eidx     (s_eidx[g]),
      .fidx     (s_fidx[g]),
      .adv      (adv),
      .frm_last (frm_last),
      .blk_last (blk_last),
      .addr     (s_addr[g]),
      .misalign (s_mis[g])
    );
  end

  assign src_addr     = s_addr[0];
  assign dst_addr     = s_addr[1];
  assign src_misalign = s_mis[0];
  assign dst_misalign = s_mis[1];
  assign frame_end    = adv && frm_last;
  assign block_end    = adv && blk_last;

endmodule

// File: rtl/dma_agen_chk.sv
module dma_agen_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic [2*CNT_W-1:0] xfer_count,
  input logic [1:0]        rd_size,
  input logic [1:0]        src_mode,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [CNT_W-1:0]  elem_left,
  input logic [CNT_W-1:0]  frame_left,
  input logic              frame_end,
  input logic              block_end,
  input logic              src_misalign,
  input logic              adv
);

  AST_BLOCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    block_end |-> frame_end); // R10

  AST_FRAME_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (elem_left == CNT_W'(1))); // R9

  AST_ELEM_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !frame_end) |=> (elem_left == $past(elem_left) - CNT_W'(1))); // R9

  AST_FRAME_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !block_end) |=> (frame_left == $past(frame_left) - CNT_W'(1))); // R9

  AST_SRC_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !block_end && (src_mode == 2'd0 || src_mode == 2'd3)) |=> $stable(src_addr)); // R3

  AST_SRC_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !block_end && src_mode == 2'd1)
      |=> (src_addr == $past(src_addr) + (ADDR_W'(1) << $past(rd_size)))); // R4

  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && elem_left == '0) |=> ($stable(src_addr) && $stable(dst_addr))); // R12

  AST_LOAD_ELEMS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && xfer_count[CNT_W-1:0] != '0) |=> (elem_left == $past(xfer_count[CNT_W-1:0]))); // R1

  AST_SRC_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    src_misalign == ((src_addr & ((ADDR_W'(1) << rd_size) - ADDR_W'(1))) != '0)); // R8

endmodule

bind dma_agen dma_agen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load         (load),
  .xfer_count   (xfer_count),
  .rd_size      (rd_size),
  .src_mode     (src_mode),
  .src_addr     (src_addr),
  .dst_addr     (dst_addr),
  .elem_left    (elem_left),
  .frame_left   (frame_left),
  .frame_end    (frame_end),
  .block_end    (block_end),
  .src_misalign (src_misalign),
  .adv          (adv)
);

// File: tb/sim_dma_agen.sv
module sim_dma_agen;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  sm, dm, rs, ws;
    logic [15:0] ne, nf;
    logic [12:0] sei, sfi, dei, dfi;
    logic [31:0] sa, da;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    // post-increment both sides, offsets present but ignored (R4, R2)
    '{2'd1, 2'd1, 2'd2, 2'd2, 16'd4, 16'd3, 13'd100, 13'd200, 13'd300, 13'd400, 32'h1000, 32'h2000},
    // indexed, src forward, dst rewinds each frame with negative frame index (R5, R11)
    '{2'd2, 2'd2, 2'd2, 2'd2, 16'd4, 16'd3, 13'd4, 13'd256, 13'd4, 13'h1FF4, 32'h3000, 32'h4000},
    // raw byte index 2 on 8-byte elements, dst constant (R6, R8, R3)
    '{2'd2, 2'd0, 2'd3, 2'd0, 16'd3, 16'd2, 13'd2, 13'd6, 13'd8, 13'd8, 32'h5000, 32'h6001},
    // zero indices hold src, dst in code-3 constant (R7, R3)
    '{2'd2, 2'd3, 2'd1, 2'd3, 16'd3, 16'd3, 13'd0, 13'd0, 13'd5, 13'd5, 32'h7002, 32'h8008},
    // mixed sizes post-increment (R2)
    '{2'd1, 2'd1, 2'd0, 2'd1, 16'd5, 16'd2, 13'd0, 13'd0, 13'd0, 13'd0, 32'h9001, 32'hA000},
    // one element per frame, negative frame index on src (R5, R11, R9)
    '{2'd2, 2'd1, 2'd2, 2'd3, 16'd1, 16'd4, 13'd64, 13'h1FF0, 13'd0, 13'd0, 32'h0100, 32'hB000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] src_start = '0, dst_start = '0, xfer_count = '0;
  logic [1:0]  rd_size = '0, wr_size = '0, src_mode = '0, dst_mode = '0;
  logic [12:0] src_eidx = '0, src_fidx = '0, dst_eidx = '0, dst_fidx = '0;
  logic        elem_done = 1'b0;
  logic [31:0] src_addr, dst_addr;
  logic [15:0] elem_left, frame_left;
  logic        frame_end, block_end, src_misalign, dst_misalign;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_agen u0 (
    .clk(clk), .rst_n(rst_n), .load(load),
    .src_start(src_start), .dst_start(dst_start), .xfer_count(xfer_count),
    .rd_size(rd_size), .wr_size(wr_size), .src_mode(src_mode), .dst_mode(dst_mode),
    .src_eidx(src_eidx), .src_fidx(src_fidx), .dst_eidx(dst_eidx), .dst_fidx(dst_fidx),
    .elem_done(elem_done),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .elem_left(elem_left), .frame_left(frame_left),
    .frame_end(frame_end), .block_end(block_end),
    .src_misalign(src_misalign), .dst_misalign(dst_misalign)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Closed-form expected offset of element n from the block start
  function automatic int exp_off(input logic [1:0] m, input logic [1:0] sz, input int ne,
                                 input logic [12:0] ei, input logic [12:0] fi, input int n);
    int f, k, e_i, f_i;
    f = n / ne;
    k = n % ne;
    e_i = int'($signed(ei));
    f_i = int'($signed(fi));
    if (m == 2'd1) return n * (1 << sz);
    if (m == 2'd2) return f * (f_i + (ne - 1) * e_i) + k * e_i;
    return 0;
  endfunction

  task automatic start_block(input logic [31:0] sa, input logic [31:0] da, input logic [31:0] cnt);
    @(negedge clk);
    src_start = sa; dst_start = da; xfer_count = cnt;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int ne, nf;
    logic [31:0] ea, eb;
    ne = int'(v.ne);
    nf = int'(v.nf);
    src_mode = v.sm; dst_mode = v.dm; rd_size = v.rs; wr_size = v.ws;
    src_eidx = v.sei; src_fidx = v.sfi; dst_eidx = v.dei; dst_fidx = v.dfi;
    start_block(v.sa, v.da, {v.nf, v.ne});
    for (int n = 0; n < ne * nf; n++) begin
      elem_done = 1'b1;
      #1;
      ea = v.sa + 32'(exp_off(v.sm, v.rs, ne, v.sei, v.sfi, n));
      eb = v.da + 32'(exp_off(v.dm, v.ws, ne, v.dei, v.dfi, n));
      chk("R4/R5/R3", "src_addr", src_addr, ea);   // mode-specific stepping
      chk("R4/R5/R3", "dst_addr", dst_addr, eb);
      chk("R8", "src_misalign", 32'(src_misalign), 32'((ea % (32'd1 << v.rs)) != 0));
      chk("R8", "dst_misalign", 32'(dst_misalign), 32'((eb % (32'd1 << v.ws)) != 0));
      chk("R9", "elem_left", 32'(elem_left), 32'(ne - n % ne));
      chk("R9", "frame_left", 32'(frame_left), 32'(nf - n / ne));
      chk("R9", "frame_end", 32'(frame_end), 32'(n % ne == ne - 1));
      chk("R10", "block_end", 32'(block_end), 32'(n == ne * nf - 1));
      @(negedge clk);
    end
    elem_done = 1'b0;
    #1;
    chk("R10", "src_addr after block", src_addr, v.sa);
    chk("R10", "dst_addr after block", dst_addr, v.da);
    chk("R10", "elem_left reload", 32'(elem_left), 32'(ne));
    chk("R10", "frame_left reload", 32'(frame_left), 32'(nf));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R12", "reset src_addr", src_addr, 32'h0);
    chk("R12", "reset dst_addr", dst_addr, 32'h0);
    chk("R12", "reset elem_left", 32'(elem_left), 32'h0);
    chk("R12", "reset frame_end", 32'(frame_end), 32'h0);
    rst_n = 1'b1;

    // R12: strobe while idle has no effect
    @(negedge clk);
    src_mode = 2'd1; dst_mode = 2'd1; rd_size = 2'd2; wr_size = 2'd2;
    elem_done = 1'b1;
    #1;
    chk("R12", "idle frame_end", 32'(frame_end), 32'h0);
    @(negedge clk);
    elem_done = 1'b0;
    #1;
    chk("R12", "idle src_addr", src_addr, 32'h0);
    chk("R12", "idle elem_left", 32'(elem_left), 32'h0);

    // Table sweep
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R1: zero count word acts as one element, one frame
    src_mode = 2'd1; dst_mode = 2'd1; rd_size = 2'd2; wr_size = 2'd2;
    start_block(32'hC000, 32'hD000, 32'h0);
    #1;
    chk("R1", "zero count elem_left", 32'(elem_left), 32'd1);
    chk("R1", "zero count frame_left", 32'(frame_left), 32'd1);
    chk("R1", "src_start captured", src_addr, 32'hC000);
    elem_done = 1'b1;
    #1;
    chk("R10", "zero count block_end", 32'(block_end), 32'd1);
    @(negedge clk);
    elem_done = 1'b0;

    // R1: split of count word, and load wins over a simultaneous strobe
    start_block(32'h100, 32'h200, {16'd5, 16'd7});
    elem_done = 1'b1;
    @(negedge clk);
    elem_done = 1'b0;
    #1;
    chk("R1", "elem_left mid", 32'(elem_left), 32'd6);
    @(negedge clk);
    src_start = 32'hE000; dst_start = 32'hF000; xfer_count = {16'd9, 16'd3};
    load = 1'b1; elem_done = 1'b1;
    @(negedge clk);
    load = 1'b0; elem_done = 1'b0;
    #1;
    chk("R1", "load priority src_addr", src_addr, 32'hE000);
    chk("R1", "load priority dst_addr", dst_addr, 32'hF000);
    chk("R1", "load elem_left", 32'(elem_left), 32'd3);
    chk("R1", "load frame_left", 32'(frame_left), 32'd9);

    @(negedge clk);
    finish_run();
  end

endmodule